// File: doc/BRIEF.md
# Audio DMA ring pointer unit

This block keeps the pointer state for two audio DMA channels that move data through ring buffers in fixed 32-byte chunks. Channel 0 captures audio: the hardware side owns the write pointer and software owns the read pointer. Channel 1 plays audio: the hardware side owns the read pointer and software owns the write pointer. Each channel has one 32-bit control word. It sets the ring size, the enable, a trigger pointer with its slice code, and the software-owned pointer.

A data mover pulses an advance strobe each time it has moved one chunk on a channel. The block steps that channel's hardware pointer and wraps it at the ring size. It gives out the current byte offset of the next chunk. When the ring is full or empty it stalls and raises an overflow or underflow pulse. When the new pointer lands on the programmed slice boundary it raises a trigger pulse. The playback channel also holds the output sample. That sample is zero while playback is off. It takes the mover's data on every accepted chunk and repeats the last value while playback is starved.

Top module: `dma_ring_ptr_unit`

## Requirements
- R1: While `rst` is high, on the next clock edge both addresses, all event pulses and `play_sample` become zero.
- R2: Each accepted advance strobe increments the channel's hardware chunk pointer by one on the next edge. The pointer wraps to zero at 2^(size+1) chunks. Size codes 0 and 1 act as code 2, which gives 8 chunks. The address output is the pointer times 32.
- R3: On the capture channel, a strobe whose increment would make the hardware pointer equal to the software read pointer leaves the pointer unchanged and pulses `cap_ovf` for one cycle.
- R4: On the playback channel, a strobe that arrives while the hardware pointer equals the software write pointer leaves the pointer unchanged and pulses `play_unf` for one cycle.
- R5: A trigger pulses for one cycle when the pointer steps to a value that agrees with the trigger pointer in every bit of the mask `(1<<(8-code))-1`. Code 0 compares all 8 bits. So code c fires once every 2^(8-c) chunks, and a stall never fires a trigger.
- R6: Strobes are ignored while the channel is disabled. A control write in the same cycle as a strobe on that channel takes precedence, and the strobe is dropped.
- R7: A control write with enable 0 and both pointer fields 0 returns the hardware pointer to zero. A write with enable 0 and a nonzero pointer field leaves it where it was. Re-enabling resumes from that pointer.
- R8: A control write with bit 31 set clears the whole channel, including the hardware pointer and the enable.
- R9: `play_sample` is zero while playback is disabled. It loads `play_din` on each accepted playback strobe and keeps its value during underflow. It returns to zero on the edge of the write that disables playback or resets the channel.
- R10: The control word fields are: bit 31 reset, bits 30:28 size code, bit 27 enable, bits 26:24 trigger code, bits 23:16 trigger pointer, bits 15:8 read pointer, bits 7:0 write pointer. The capture channel takes its software pointer from the read-pointer field. The playback channel takes its software pointer from the write-pointer field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 2 | Control write strobe per channel (bit 0 capture, bit 1 playback) |
| ctl_wdata | input | 32 | Control word for the written channel(s) |
| mv_adv | input | 2 | Chunk-moved strobe from the data mover, per channel |
| play_din | input | 16 | Sample delivered with a playback strobe |
| cap_addr | output | 13 | Byte offset of the capture hardware pointer |
| play_addr | output | 13 | Byte offset of the playback hardware pointer |
| cap_trig | output | 1 | Capture trigger pulse |
| cap_ovf | output | 1 | Capture overflow pulse |
| play_trig | output | 1 | Playback trigger pulse |
| play_unf | output | 1 | Playback underflow pulse |
| play_sample | output | 16 | Current playback output sample |

## Verification
The bench drives both rings into their stall points. A design that compared the wrong pointer there would let capture overrun the reader by one chunk, or let playback read a chunk software never wrote. It also wraps a ring sized by an illegal code and uses code 0 triggering. An unclamped size would walk past chunk 7, and a mask that reads code 0 literally would fire on every chunk. It runs disable-with-clear against disable-without-clear and a write colliding with a strobe, which catches a pointer that fails to return to the ring start or that moves on a dropped strobe. Finally it checks that the played sample repeats during underflow and drops to zero on disable. A design that latched the stale sample would keep driving it after playback stops.

// File: rtl/dmaring_pkg.sv
package dmaring_pkg;
  localparam int PTR_W       = 8;
  localparam int CHUNK_SHIFT = 5;
  localparam int ADDR_W      = PTR_W + CHUNK_SHIFT;
  localparam int CODE_W      = 3;

  // Control word, MSB first; positions are fixed by software convention.
  typedef struct packed {
    logic              clr;
    logic [CODE_W-1:0] size;
    logic              en;
    logic [CODE_W-1:0] tcode;
    logic [PTR_W-1:0]  tptr;
    logic [PTR_W-1:0]  rptr;
    logic [PTR_W-1:0]  wptr;
  } ctl_word_t;

  // Chunk-count mask of the ring: 2^(size+1) chunks, size clamped to >= 2.
  function automatic logic [PTR_W-1:0] ring_mask(input logic [CODE_W-1:0] sz);
    int e;
    e = (sz < 3'd2) ? 2 : int'(sz);
    return PTR_W'((1 << (e + 1)) - 1);
  endfunction

  // Compared bits of the trigger: low (8-code) bits, all bits for code 0.
  function automatic logic [PTR_W-1:0] trig_mask(input logic [CODE_W-1:0] code);
    if (code == '0) return '1;
    return PTR_W'((1 << (PTR_W - int'(code))) - 1);
  endfunction
endpackage

// File: rtl/dmaring_trig_cmp.sv
module dmaring_trig_cmp
  import dmaring_pkg::*;
(
  input  logic [PTR_W-1:0]  ptr,
  input  logic [PTR_W-1:0]  tptr,
  input  logic [CODE_W-1:0] code,
  output logic              hit
);
  always_comb hit = ((ptr ^ tptr) & trig_mask(code)) == '0;
endmodule

// File: rtl/dmaring_chan.sv
module dmaring_chan
  import dmaring_pkg::*;
#(
  parameter bit IS_PLAY = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  ctl_word_t        ctl_w,
  input  logic             adv,
  output logic [PTR_W-1:0] hw_ptr,
  output logic             en,
  output logic             step,
  output logic             trig,
  output logic             stall_evt
);
  logic [CODE_W-1:0] size_q, tcode_q;
  logic [PTR_W-1:0]  tptr_q, sw_q, hw_q;
  logic              en_q, trig_q, evt_q;

  logic [PTR_W-1:0]  hw_inc;
  logic              blocked, go, hit;

  always_comb begin
    hw_inc  = (hw_q + 1'b1) & ring_mask(size_q);
    blocked = IS_PLAY ? (hw_q == sw_q) : (hw_inc == sw_q);
    go      = adv && en_q && !ctl_wr;
    step    = go && !blocked;
  end

  dmaring_trig_cmp u_cmp (
    .ptr  (hw_inc),
    .tptr (tptr_q),
    .code (tcode_q),
    .hit  (hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      size_q  <= '0;
      tcode_q <= '0;
      tptr_q  <= '0;
      sw_q    <= '0;
      hw_q    <= '0;
      en_q    <= 1'b0;
      trig_q  <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      trig_q <= step && hit;
      evt_q  <= go && blocked;
      if (ctl_wr) begin
        if (ctl_w.clr) begin
          size_q  <= '0;
          tcode_q <= '0;
          tptr_q  <= '0;
          sw_q    <= '0;
          hw_q    <= '0;
          en_q    <= 1'b0;
        end else begin
          size_q  <= ctl_w.size;
          tcode_q <= ctl_w.tcode;
          tptr_q  <= ctl_w.tptr;
          en_q    <= ctl_w.en;
          sw_q    <= IS_PLAY ? ctl_w.wptr : ctl_w.rptr;
          if (!ctl_w.en && ctl_w.rptr == '0 && ctl_w.wptr == '0)
            hw_q <= '0;
        end
      end else if (step) begin
        hw_q <= hw_inc;
      end
    end
  end

  assign hw_ptr    = hw_q;
  assign en        = en_q;
  assign trig      = trig_q;
  assign stall_evt = evt_q;
endmodule

// File: rtl/dmaring_sample_hold.sv
module dmaring_sample_hold #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                zero,
  input  logic                load,
  input  logic [SAMPLE_W-1:0] din,
  output logic [SAMPLE_W-1:0] sample
);
  always_ff @(posedge clk) begin
    if (rst || zero) sample <= '0;
    else if (load)   sample <= din;
  end
endmodule

// File: rtl/dma_ring_ptr_unit.sv
module dma_ring_ptr_unit
  import dmaring_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int N_CHAN   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          ctl_wr,
  input  logic [31:0]         ctl_wdata,
  input  logic [1:0]          mv_adv,
  input  logic [SAMPLE_W-1:0] play_din,
  output logic [ADDR_W-1:0]   cap_addr,
  output logic [ADDR_W-1:0]   play_addr,
  output logic                cap_trig,
  output logic                cap_ovf,
  output logic                play_trig,
  output logic                play_unf,
  output logic [SAMPLE_W-1:0] play_sample
);
  localparam int CAP  = 0;
  localparam int PLAY = 1;

  ctl_word_t        w;
  logic [PTR_W-1:0] hw   [N_CHAN];
  logic             en   [N_CHAN];
  logic             step [N_CHAN];
  logic             trig [N_CHAN];
  logic             evt  [N_CHAN];
  logic             zero_play;

  assign w = ctl_word_t'(ctl_wdata);

  for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
    dmaring_chan #(.IS_PLAY(g == PLAY)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .ctl_wr    (ctl_wr[g]),
      .ctl_w     (w),
      .adv       (mv_adv[g]),
      .hw_ptr    (hw[g]),
      .en        (en[g]),
      .step      (step[g]),
      .trig      (trig[g]),
      .stall_evt (evt[g])
    );
  end

  // Zero on the edge of a disabling/clearing write, and whenever idle.
  assign zero_play = ctl_wr[PLAY] ? (w.clr || !w.en) : !en[PLAY];

  dmaring_sample_hold #(.SAMPLE_W(SAMPLE_W)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .zero   (zero_play),
    .load   (step[PLAY]),
    .din    (play_din),
    .sample (play_sample)
  );

  assign cap_addr  = {hw[CAP],  {CHUNK_SHIFT{1'b0}}};
  assign play_addr = {hw[PLAY], {CHUNK_SHIFT{1'b0}}};
  assign cap_trig  = trig[CAP];
  assign cap_ovf   = evt[CAP];
  assign play_trig = trig[PLAY];
  assign play_unf  = evt[PLAY];
endmodule

// File: rtl/dmaring_chk.sv
module dmaring_chk
  import dmaring_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic [1:0]          ctl_wr,
  input logic [1:0]          mv_adv,
  input logic [ADDR_W-1:0]   cap_addr,
  input logic [ADDR_W-1:0]   play_addr,
  input logic                cap_trig,
  input logic                cap_ovf,
  input logic                play_trig,
  input logic                play_unf,
  input logic [SAMPLE_W-1:0] play_sample
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (cap_addr == '0 && play_addr == '0 && !cap_trig && !cap_ovf
             && !play_trig && !play_unf && play_sample == '0));

  a_r3_ovf_stall: assert property (@(posedge clk) disable iff (rst)
    cap_ovf |-> (cap_addr == $past(cap_addr) && !cap_trig));

  a_r4_unf_stall: assert property (@(posedge clk) disable iff (rst)
    play_unf |-> (play_addr == $past(play_addr) && !play_trig));

  a_r5_trig_on_move: assert property (@(posedge clk) disable iff (rst)
    cap_trig |-> cap_addr != $past(cap_addr));

  a_r5_play_trig_on_move: assert property (@(posedge clk) disable iff (rst)
    play_trig |-> play_addr != $past(play_addr));

  a_r6_idle_cap: assert property (@(posedge clk) disable iff (rst)
    (!$past(mv_adv[0]) && !$past(ctl_wr[0])) |->
      (cap_addr == $past(cap_addr) && !cap_trig && !cap_ovf));

  a_r6_idle_play: assert property (@(posedge clk) disable iff (rst)
    (!$past(mv_adv[1]) && !$past(ctl_wr[1])) |->
      (play_addr == $past(play_addr) && !play_trig && !play_unf));

  a_r9_unf_holds_sample: assert property (@(posedge clk) disable iff (rst)
    play_unf |-> play_sample == $past(play_sample));
endmodule

bind dma_ring_ptr_unit dmaring_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ctl_wr      (ctl_wr),
  .mv_adv      (mv_adv),
  .cap_addr    (cap_addr),
  .play_addr   (play_addr),
  .cap_trig    (cap_trig),
  .cap_ovf     (cap_ovf),
  .play_trig   (play_trig),
  .play_unf    (play_unf),
  .play_sample (play_sample)
);

// File: tb/tb_dma_ring_ptr_unit.sv
module tb_dma_ring_ptr_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  ctl_wr = '0;
  logic [31:0] ctl_wdata = '0;
  logic [1:0]  mv_adv = '0;
  logic [15:0] play_din = '0;
  logic [12:0] cap_addr, play_addr;
  logic        cap_trig, cap_ovf, play_trig, play_unf;
  logic [15:0] play_sample;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dma_ring_ptr_unit dut (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .mv_adv(mv_adv), .play_din(play_din), .cap_addr(cap_addr),
    .play_addr(play_addr), .cap_trig(cap_trig), .cap_ovf(cap_ovf),
    .play_trig(play_trig), .play_unf(play_unf), .play_sample(play_sample)
  );

  // {adv, ch, data[31:0], exp_ptr[7:0], exp_trig, exp_evt}
  localparam int NV = 32;
  localparam logic [43:0] TV [NV] = '{
    // playback: ring 8, trig code 6 (every 4), wptr 3
    {1'b0,1'b1,32'h2E000003,8'd0,1'b0,1'b0},
    {1'b1,1'b1,32'h0,8'd1,1'b0,1'b0},
    {1'b1,1'b1,32'h0,8'd2,1'b0,1'b0},
    {1'b1,1'b1,32'h0,8'd3,1'b0,1'b0},
    {1'b1,1'b1,32'h0,8'd3,1'b0,1'b1},   // R4 underflow
    {1'b0,1'b1,32'h2E000006,8'd3,1'b0,1'b0},
    {1'b1,1'b1,32'h0,8'd4,1'b1,1'b0},   // R5 slice boundary
    {1'b1,1'b1,32'h0,8'd5,1'b0,1'b0},
    {1'b1,1'b1,32'h0,8'd6,1'b0,1'b0},
    {1'b1,1'b1,32'h0,8'd6,1'b0,1'b1},
    {1'b0,1'b1,32'h2E000002,8'd6,1'b0,1'b0},
    {1'b1,1'b1,32'h0,8'd7,1'b0,1'b0},
    {1'b1,1'b1,32'h0,8'd0,1'b1,1'b0},   // R2 wrap
    {1'b1,1'b1,32'h0,8'd1,1'b0,1'b0},
    {1'b1,1'b1,32'h0,8'd2,1'b0,1'b0},
    {1'b1,1'b1,32'h0,8'd2,1'b0,1'b1},
    // capture: ring 16, trig code 7 tptr 1 (odd chunks), rptr 4
    {1'b0,1'b0,32'h3F010400,8'd0,1'b0,1'b0},
    {1'b1,1'b0,32'h0,8'd1,1'b1,1'b0},
    {1'b1,1'b0,32'h0,8'd2,1'b0,1'b0},
    {1'b1,1'b0,32'h0,8'd3,1'b1,1'b0},
    {1'b1,1'b0,32'h0,8'd3,1'b0,1'b1},   // R3 overflow
    {1'b0,1'b0,32'h3F010000,8'd3,1'b0,1'b0},
    {1'b1,1'b0,32'h0,8'd4,1'b0,1'b0},
    {1'b0,1'b0,32'h30000000,8'd0,1'b0,1'b0}, // R7 disable+clear
    {1'b1,1'b0,32'h0,8'd0,1'b0,1'b0},   // R6 ignored while disabled
    {1'b0,1'b0,32'h3F010400,8'd0,1'b0,1'b0}, // R7 restart at ring start
    {1'b1,1'b0,32'h0,8'd1,1'b1,1'b0},
    {1'b1,1'b0,32'h0,8'd2,1'b0,1'b0},
    {1'b0,1'b0,32'h37010400,8'd2,1'b0,1'b0}, // R7 disable, keep position
    {1'b1,1'b0,32'h0,8'd2,1'b0,1'b0},
    {1'b0,1'b0,32'h3F010400,8'd2,1'b0,1'b0},
    {1'b1,1'b0,32'h0,8'd3,1'b1,1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op(input bit adv, input bit ch, input logic [31:0] data,
                    input logic [15:0] din);
    @(negedge clk);
    if (adv) mv_adv[ch] = 1'b1;
    else begin ctl_wr[ch] = 1'b1; ctl_wdata = data; end
    play_din = din;
    @(negedge clk);
    mv_adv = '0;
    ctl_wr = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 cap_addr", 32'(cap_addr), 0);
    chk("R1 play_addr", 32'(play_addr), 0);
    chk("R1 events", {28'd0, cap_trig, cap_ovf, play_trig, play_unf}, 0);
    chk("R1 sample", 32'(play_sample), 0);
    rst = 1'b0;

    // R10 field layout and R2..R5 behaviour via the vector table
    for (int i = 0; i < NV; i++) begin
      logic        v_adv, v_ch, v_tr, v_ev;
      logic [31:0] v_data;
      logic [7:0]  v_ptr;
      string       tag;
      {v_adv, v_ch, v_data, v_ptr, v_tr, v_ev} = TV[i];
      op(v_adv, v_ch, v_data, 16'h0);
      if (!v_adv)    tag = "R10";
      else if (v_ev) tag = v_ch ? "R4" : "R3";
      else if (v_tr) tag = "R5";
      else           tag = "R2";
      chk($sformatf("%s vec%0d addr", tag, i), 32'(v_ch ? play_addr : cap_addr), {19'd0, v_ptr, 5'd0});
      chk($sformatf("%s vec%0d trig", tag, i), 32'(v_ch ? play_trig : cap_trig), 32'(v_tr));
      chk($sformatf("%s vec%0d evt", tag, i), 32'(v_ch ? play_unf : cap_ovf), 32'(v_ev));
      chk($sformatf("%s vec%0d other", tag, i),
          32'(v_ch ? (cap_trig | cap_ovf) : (play_trig | play_unf)), 0);
    end

    // R8: reset bit clears pointer and enable
    op(1'b0, 1'b0, 32'h80000000, 16'h0);
    chk("R8 cap_addr cleared", 32'(cap_addr), 0);
    op(1'b1, 1'b0, 32'h0, 16'h0);
    chk("R8 enable cleared", 32'(cap_addr), 0);

    // R6: write and strobe in the same cycle, write wins
    @(negedge clk);
    ctl_wr[0] = 1'b1; ctl_wdata = 32'h3F010400; mv_adv[0] = 1'b1;
    @(negedge clk);
    ctl_wr = '0; mv_adv = '0;
    chk("R6 strobe dropped on write", 32'(cap_addr), 0);
    chk("R6 no trig on dropped strobe", 32'(cap_trig), 0);
    op(1'b1, 1'b0, 32'h0, 16'h0);
    chk("R6 next strobe moves", 32'(cap_addr), 32);

    // R2 illegal size code 0 acts as 8 chunks; R5 code 0 compares all bits
    op(1'b0, 1'b1, 32'h80000000, 16'h0);
    op(1'b0, 1'b1, 32'h080000FF, 16'h0);
    for (int k = 0; k < 7; k++) op(1'b1, 1'b1, 32'h0, 16'h0);
    chk("R2 clamp ptr 7", 32'(play_addr), 7 * 32);
    chk("R5 code0 no early trig", 32'(play_trig), 0);
    op(1'b1, 1'b1, 32'h0, 16'h0);
    chk("R2 clamp wraps at 8", 32'(play_addr), 0);
    chk("R5 code0 fires at tptr", 32'(play_trig), 1);

    // R9 playback sample path
    op(1'b0, 1'b1, 32'h80000000, 16'h0);
    chk("R9 zero when disabled", 32'(play_sample), 0);
    op(1'b0, 1'b1, 32'h2E000001, 16'h0);
    op(1'b1, 1'b1, 32'h0, 16'h1234);
    chk("R9 sample loaded", 32'(play_sample), 32'h1234);
    op(1'b1, 1'b1, 32'h0, 16'h5555);
    chk("R9 underflow flag", 32'(play_unf), 1);
    chk("R9 sample repeated", 32'(play_sample), 32'h1234);
    op(1'b0, 1'b1, 32'h26000000, 16'h0);
    chk("R9 zero after disable", 32'(play_sample), 0);
    chk("R7 play ptr cleared", 32'(play_addr), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule